// File: doc/BRIEF.md
# Indexed Real-Time-Clock Register File

This block is the host-facing register file of a real-time clock. A host reaches it through a byte-wide port that has only two addresses. A write to the even address selects one of 128 byte locations by storing a 7-bit index. A read or write at the odd address then reaches the selected location. Four fixed locations are control registers rather than plain storage:

| Index | Register |
|-------|----------|
| 10 | Rate and divider, which carries the update-in-progress bit |
| 11 | Mode, which carries the set bit and the interrupt enables |
| 12 | Interrupt flags |
| 13 | Validity |

Time keeping is done outside the block. An external counter signals the start and the end of each one-second update with strobes, and presents the current seconds, minutes and hours bytes. A separate strobe marks each periodic tick.

The block merges three interrupt sources into one level request line: the periodic tick, the alarm match and the update-ended event. Reading the flag register returns the flags, clears them and drops the request line, all in the same access. A system reset input clears the interrupt enables and the flags without touching the rest of the state. The power-on reset returns everything to its defaults.

Top module: `rtc_regfile`

## Requirements
- R1: A write with `busAddr`=0 stores `busWdata[6:0]` as the index, and bit 7 of the data is dropped. A read with `busAddr`=0 returns 0xFF.
- R2: At `busAddr`=1, a write stores the byte at any index other than 10 to 13, and a read of that index returns the stored byte.
- R3: A host write to the rate register (index 10) stores bits 6:0 and leaves bit 7 (update in progress) unchanged.
- R4: Host writes to the flag register (index 12) and the validity register (index 13) have no effect.
- R5: A write to the mode register (index 11) with bit 7 (set) high stores the data with bit 4 (update-ended enable) forced to 0, and clears bit 7 of the rate register.
- R6: A read of the flag register returns its contents. After that access the register holds 0x00 and `irqOut` is low, unless an event arrives in the same cycle.
- R7: After power-on reset the registers hold rate = 0x26, mode = 0x02, flags = 0x00 and validity = 0x80, and `irqOut` is low.
- R8: A `sysReset` pulse clears bits 6, 5 and 3 of the mode register and bits 7 to 4 of the flag register, and drops `irqOut`. All other mode bits are kept.
- R9: At `updDone`, with mode bit 5 set, the alarm bytes at indices 1, 3 and 5 are compared against `nowSec`, `nowMin` and `nowHour`. Each byte matches if it equals its value, or if its bits 7:6 are both 1. When all three match, 0xA0 is ORed into the flags and `irqOut` rises. Any mismatch adds nothing.
- R10: `updBegin` sets rate bit 7 when mode bit 7 is clear. `updDone` clears rate bit 7. With mode bit 4 set, `updDone` also ORs 0x90 into the flags and raises `irqOut`.
- R11: `tickPeriodic` with mode bit 6 set ORs 0xC0 into the flags and raises `irqOut`.
- R12: `irqOut` is a level signal. It stays high until the flag register is read or `sysReset` is pulsed. Flags set in the same cycle as a flag read survive that read.
- R13: `updDone` copies `nowSec`, `nowMin` and `nowHour` into indices 0, 2 and 4 when mode bit 7 is clear, and leaves them untouched when mode bit 7 is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset to the default values |
| sysReset | input | 1 | Synchronous system reset that clears the enables and the flags |
| busWr | input | 1 | Host write strobe |
| busRd | input | 1 | Host read strobe |
| busAddr | input | 1 | Port select: 0 for the index, 1 for data |
| busWdata | input | 8 | Host write data |
| busRdata | output | 8 | Host read data |
| tickPeriodic | input | 1 | Periodic tick strobe |
| updBegin | input | 1 | Strobe marking the start of an update |
| updDone | input | 1 | Strobe marking the end of an update |
| nowSec | input | 8 | Current seconds byte |
| nowMin | input | 8 | Current minutes byte |
| nowHour | input | 8 | Current hours byte |
| irqOut | output | 1 | Interrupt request, level |

## Verification
A corrupted flag register or request latch shows up on `irqOut` one cycle after the event that should have set or cleared it. It shows up again at the next read of index 12, which returns the wrong byte combinationally in that same access.

A wrong index or a wrong protection decode appears on the very next odd-address read. A write that should have been dropped reads back as changed, and a kept update-in-progress bit reads back as lost.

The alarm comparison and the time copy show up only at an `updDone`. The bench therefore reads the flags and the time bytes right after each update strobe.

// File: rtl/rtc_regfile_pkg.sv
package rtc_regfile_pkg;
  localparam int IDX_W  = 7;
  localparam int DATA_W = 8;

  // Fixed locations of the control registers and the time/alarm bytes
  localparam logic [IDX_W-1:0] IDX_RATE  = 7'd10;
  localparam logic [IDX_W-1:0] IDX_MODE  = 7'd11;
  localparam logic [IDX_W-1:0] IDX_FLAG  = 7'd12;
  localparam logic [IDX_W-1:0] IDX_VALID = 7'd13;
  localparam logic [IDX_W-1:0] IDX_SEC   = 7'd0;
  localparam logic [IDX_W-1:0] IDX_MIN   = 7'd2;
  localparam logic [IDX_W-1:0] IDX_HOUR  = 7'd4;
  localparam logic [IDX_W-1:0] IDX_ASEC  = 7'd1;
  localparam logic [IDX_W-1:0] IDX_AMIN  = 7'd3;
  localparam logic [IDX_W-1:0] IDX_AHOUR = 7'd5;

  // Strobes from control to datapath
  typedef struct packed {
    logic             wrMem;
    logic             wrRate;
    logic             wrMode;
    logic             rdFlags;
    logic             setUip;
    logic             updDone;
    logic             copyTime;
    logic             perTick;
    logic [IDX_W-1:0] idx;
  } rtcStrobes_t;
endpackage

// File: rtl/rtc_regfile_ctrl.sv
module rtc_regfile_ctrl
  import rtc_regfile_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busWr,
  input  logic             busRd,
  input  logic             busAddr,
  input  logic [IDX_W-1:0] idxData,
  input  logic             tickPeriodic,
  input  logic             updBegin,
  input  logic             updDone,
  input  logic             setMode,
  output rtcStrobes_t      strb
);
  logic [IDX_W-1:0] idxReg;
  logic             hostWr;
  logic             isCtrl;

  // Index latch, loaded by writes to the even address
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 idxReg <= '0;
    else if (busWr && !busAddr) idxReg <= idxData;
  end

  always_comb begin
    hostWr        = busWr && busAddr;
    isCtrl        = (idxReg >= IDX_RATE) && (idxReg <= IDX_VALID);
    strb.idx      = idxReg;
    strb.wrMem    = hostWr && !isCtrl;
    strb.wrRate   = hostWr && (idxReg == IDX_RATE);
    strb.wrMode   = hostWr && (idxReg == IDX_MODE);
    strb.rdFlags  = busRd && busAddr && (idxReg == IDX_FLAG);
    // Update strobes are gated by the set bit of the mode register
    strb.setUip   = updBegin && !setMode;
    strb.updDone  = updDone;
    strb.copyTime = updDone && !setMode;
    strb.perTick  = tickPeriodic;
  end
endmodule

// File: rtl/rtc_regfile_dp.sv
module rtc_regfile_dp
  import rtc_regfile_pkg::*;
#(
  parameter logic [DATA_W-1:0] RATE_INIT  = 8'h26,
  parameter logic [DATA_W-1:0] MODE_INIT  = 8'h02,
  parameter logic [DATA_W-1:0] VALID_INIT = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sysReset,
  input  rtcStrobes_t       strb,
  input  logic [DATA_W-1:0] wData,
  input  logic [DATA_W-1:0] nowSec,
  input  logic [DATA_W-1:0] nowMin,
  input  logic [DATA_W-1:0] nowHour,
  output logic [DATA_W-1:0] rData,
  output logic [DATA_W-1:0] modeReg,
  output logic              irqOut
);
  localparam int DEPTH = 1 << IDX_W;

  // Bit positions inside the control registers
  localparam int B_UIP  = 7;
  localparam int B_SET  = 7;
  localparam int B_PIE  = 6;
  localparam int B_AIE  = 5;
  localparam int B_UIE  = 4;

  localparam logic [DATA_W-1:0] EV_PER   = 8'hC0;
  localparam logic [DATA_W-1:0] EV_ALARM = 8'hA0;
  localparam logic [DATA_W-1:0] EV_UPD   = 8'h90;
  localparam logic [DATA_W-1:0] MODE_RST_MASK = 8'h68;
  localparam logic [DATA_W-1:0] FLAG_RST_MASK = 8'hF0;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rateReg, flagReg;
  logic [DATA_W-1:0] rateNext, modeNext, flagNext, evBits;
  logic              irqReg, irqNext, uipNext;
  logic              almSec, almMin, almHour, almHit;

  // A byte matches when its top two bits mark "any" or when it equals the value
  function automatic logic almMatch(input logic [DATA_W-1:0] alm,
                                    input logic [DATA_W-1:0] now);
    return (alm[DATA_W-1:DATA_W-2] == 2'b11) || (alm == now);
  endfunction

  always_comb begin
    almSec  = almMatch(mem[IDX_ASEC],  nowSec);
    almMin  = almMatch(mem[IDX_AMIN],  nowMin);
    almHour = almMatch(mem[IDX_AHOUR], nowHour);
    almHit  = almSec && almMin && almHour;

    evBits = '0;
    if (strb.perTick && modeReg[B_PIE])                 evBits |= EV_PER;
    if (strb.updDone && modeReg[B_AIE] && almHit)       evBits |= EV_ALARM;
    if (strb.updDone && modeReg[B_UIE])                 evBits |= EV_UPD;

    // Flags: a read clears, events of the same cycle survive, system reset wins
    flagNext = (strb.rdFlags ? '0 : flagReg) | evBits;
    irqNext  = (strb.rdFlags ? 1'b0 : irqReg) | (evBits != '0);
    if (sysReset) begin
      flagNext = flagNext & ~FLAG_RST_MASK;
      irqNext  = 1'b0;
    end

    modeNext = modeReg;
    if (strb.wrMode) begin
      modeNext = wData;
      if (wData[B_SET]) modeNext[B_UIE] = 1'b0;
    end
    if (sysReset) modeNext = modeNext & ~MODE_RST_MASK;

    uipNext = rateReg[B_UIP];
    if (strb.setUip)                  uipNext = 1'b1;
    if (strb.updDone)                 uipNext = 1'b0;
    if (strb.wrMode && wData[B_SET])  uipNext = 1'b0;
    rateNext = {uipNext, strb.wrRate ? wData[DATA_W-2:0] : rateReg[DATA_W-2:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rateReg <= RATE_INIT;
      modeReg <= MODE_INIT;
      flagReg <= '0;
      irqReg  <= 1'b0;
    end else begin
      rateReg <= rateNext;
      modeReg <= modeNext;
      flagReg <= flagNext;
      irqReg  <= irqNext;
    end
  end

  // General byte storage; the host write is ordered after the time copy
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (strb.copyTime) begin
        mem[IDX_SEC]  <= nowSec;
        mem[IDX_MIN]  <= nowMin;
        mem[IDX_HOUR] <= nowHour;
      end
      if (strb.wrMem) mem[strb.idx] <= wData;
    end
  end

  always_comb begin
    case (strb.idx)
      IDX_RATE:  rData = rateReg;
      IDX_MODE:  rData = modeReg;
      IDX_FLAG:  rData = flagReg;
      IDX_VALID: rData = VALID_INIT;
      default:   rData = mem[strb.idx];
    endcase
  end

  assign irqOut = irqReg;
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
  import rtc_regfile_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sysReset,
  input  logic              busWr,
  input  logic              busRd,
  input  logic              busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              tickPeriodic,
  input  logic              updBegin,
  input  logic              updDone,
  input  logic [DATA_W-1:0] nowSec,
  input  logic [DATA_W-1:0] nowMin,
  input  logic [DATA_W-1:0] nowHour,
  output logic              irqOut
);
  rtcStrobes_t       strb;
  logic [DATA_W-1:0] modeReg;
  logic [DATA_W-1:0] dpRdata;

  rtc_regfile_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .busWr        (busWr),
    .busRd        (busRd),
    .busAddr      (busAddr),
    .idxData      (busWdata[IDX_W-1:0]),
    .tickPeriodic (tickPeriodic),
    .updBegin     (updBegin),
    .updDone      (updDone),
    .setMode      (modeReg[DATA_W-1]),
    .strb         (strb)
  );

  rtc_regfile_dp u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .sysReset (sysReset),
    .strb     (strb),
    .wData    (busWdata),
    .nowSec   (nowSec),
    .nowMin   (nowMin),
    .nowHour  (nowHour),
    .rData    (dpRdata),
    .modeReg  (modeReg),
    .irqOut   (irqOut)
  );

  assign busRdata = busAddr ? dpRdata : '1;
endmodule

// File: rtl/rtc_regfile_chk.sv
module rtc_regfile_chk
  import rtc_regfile_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              sysReset,
  input logic              busRd,
  input logic              busAddr,
  input logic [DATA_W-1:0] busRdata,
  input logic              irqOut,
  input logic [DATA_W-1:0] modeReg,
  input rtcStrobes_t       strb
);
  assert_even_read_ff_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busRd && !busAddr) |-> (busRdata == 8'hFF));

  assert_set_blocks_uie_R5: assert property (@(posedge clk) disable iff (!rst_n)
    modeReg[7] |-> !modeReg[4]);

  assert_flag_read_drops_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.rdFlags && !strb.perTick && !strb.updDone) |=> !irqOut);

  assert_sysreset_drops_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sysReset |=> !irqOut);

  assert_periodic_raises_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.perTick && modeReg[6] && !sysReset) |=> irqOut);

  assert_irq_level_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (irqOut && !strb.rdFlags && !sysReset) |=> irqOut);
endmodule

bind rtc_regfile rtc_regfile_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sysReset (sysReset),
  .busRd    (busRd),
  .busAddr  (busAddr),
  .busRdata (busRdata),
  .irqOut   (irqOut),
  .modeReg  (modeReg),
  .strb     (strb)
);

// File: tb/rtc_regfile_bench.sv
module rtc_regfile_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sysReset = 1'b0;
  logic       busWr = 1'b0, busRd = 1'b0, busAddr = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       tickPeriodic = 1'b0, updBegin = 1'b0, updDone = 1'b0;
  logic [7:0] nowSec = '0, nowMin = '0, nowHour = '0;
  logic       irqOut;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 1'b0;

  logic [7:0] expQ [$];
  string      tagQ [$];

  always #2 clk = ~clk;

  rtc_regfile u_rtc_regfile (.*);

  task automatic check(input logic [7:0] got, input logic [7:0] exp, input string tag);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  // Monitor: pops an expected byte for every read it sees on the port
  always begin
    @(negedge clk);
    #1;
    if (busRd) begin
      if (expQ.size() == 0) begin
        nChecks++; nFails++;
        $display("FAIL scoreboard: read with no expected item, got 0x%02h expected none", busRdata);
      end else begin
        check(busRdata, expQ.pop_front(), tagQ.pop_front());
      end
    end
  end

  task automatic portWrite(input logic a, input logic [7:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic portRead(input logic a, input logic [7:0] exp, input string tag,
                          input logic withTick = 1'b0);
    expQ.push_back(exp); tagQ.push_back(tag);
    @(negedge clk);
    busRd = 1'b1; busAddr = a; tickPeriodic = withTick;
    @(negedge clk);
    busRd = 1'b0; tickPeriodic = 1'b0;
  endtask

  task automatic wrReg(input logic [6:0] idx, input logic [7:0] d);
    portWrite(1'b0, {1'b0, idx});
    portWrite(1'b1, d);
  endtask

  task automatic rdReg(input logic [6:0] idx, input logic [7:0] exp, input string tag);
    portWrite(1'b0, {1'b0, idx});
    portRead(1'b1, exp, tag);
  endtask

  task automatic pulseTick();
    @(negedge clk); tickPeriodic = 1'b1;
    @(negedge clk); tickPeriodic = 1'b0;
  endtask

  task automatic pulseBegin();
    @(negedge clk); updBegin = 1'b1;
    @(negedge clk); updBegin = 1'b0;
  endtask

  task automatic pulseDone(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h);
    @(negedge clk); nowSec = s; nowMin = m; nowHour = h; updDone = 1'b1;
    @(negedge clk); updDone = 1'b0;
  endtask

  task automatic checkIrq(input logic exp, input string tag);
    @(negedge clk); #1;
    check({7'd0, irqOut}, {7'd0, exp}, tag);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R7 defaults
    checkIrq(1'b0, "R7 irq");
    rdReg(7'd10, 8'h26, "R7 rate");
    rdReg(7'd11, 8'h02, "R7 mode");
    rdReg(7'd12, 8'h00, "R7 flags");
    rdReg(7'd13, 8'h80, "R7 valid");
    // R1 even read, index bit 7 dropped
    portRead(1'b0, 8'hFF, "R1 even read");
    portWrite(1'b0, 8'hC0);
    portWrite(1'b1, 8'h33);
    rdReg(7'h40, 8'h33, "R1 index bit7 dropped");
    // R2 plain storage
    wrReg(7'h7F, 8'h5A);
    wrReg(7'h20, 8'hA5);
    rdReg(7'h7F, 8'h5A, "R2 byte 0x7F");
    rdReg(7'h20, 8'hA5, "R2 byte 0x20");
    // R10 / R3 update in progress
    pulseBegin();
    rdReg(7'd10, 8'hA6, "R10 uip set");
    wrReg(7'd10, 8'h00);
    rdReg(7'd10, 8'h80, "R3 uip kept on write");
    wrReg(7'd10, 8'hA6);
    pulseDone(8'h00, 8'h00, 8'h00);
    rdReg(7'd10, 8'h26, "R10 uip cleared");
    // R4 ignored writes
    wrReg(7'd12, 8'hFF);
    wrReg(7'd13, 8'h00);
    rdReg(7'd12, 8'h00, "R4 flags unwritten");
    rdReg(7'd13, 8'h80, "R4 valid unwritten");
    checkIrq(1'b0, "R4 irq");
    // R11 periodic
    wrReg(7'd11, 8'h42);
    pulseTick();
    checkIrq(1'b1, "R11 irq");
    rdReg(7'd12, 8'hC0, "R11 flags");
    checkIrq(1'b0, "R6 irq dropped");
    rdReg(7'd12, 8'h00, "R6 flags cleared");
    // R12 level hold and same-cycle event
    pulseTick();
    pulseTick();
    checkIrq(1'b1, "R12 irq held");
    portRead(1'b1, 8'hC0, "R12 read with tick", 1'b1);
    checkIrq(1'b1, "R12 irq survives");
    portRead(1'b1, 8'hC0, "R12 flags survive");
    checkIrq(1'b0, "R12 irq dropped");
    // R10 update-ended interrupt
    wrReg(7'd11, 8'h12);
    pulseDone(8'h01, 8'h02, 8'h03);
    checkIrq(1'b1, "R10 irq");
    rdReg(7'd12, 8'h90, "R10 flags");
    // R9 alarm
    wrReg(7'd1, 8'h15);
    wrReg(7'd3, 8'hC0);
    wrReg(7'd5, 8'h08);
    wrReg(7'd11, 8'h22);
    pulseDone(8'h15, 8'h07, 8'h08);
    checkIrq(1'b1, "R9 irq on match");
    rdReg(7'd12, 8'hA0, "R9 flags on match");
    pulseDone(8'h16, 8'h07, 8'h08);
    checkIrq(1'b0, "R9 irq on mismatch");
    rdReg(7'd12, 8'h00, "R9 flags on mismatch");
    // R13 time copy
    wrReg(7'd11, 8'h02);
    pulseDone(8'h21, 8'h34, 8'h12);
    rdReg(7'd0, 8'h21, "R13 sec");
    rdReg(7'd2, 8'h34, "R13 min");
    rdReg(7'd4, 8'h12, "R13 hour");
    // R5 set mode
    pulseBegin();
    rdReg(7'd10, 8'hA6, "R5 uip before set");
    wrReg(7'd11, 8'h92);
    rdReg(7'd11, 8'h82, "R5 uie forced off");
    rdReg(7'd10, 8'h26, "R5 uip cleared");
    pulseBegin();
    rdReg(7'd10, 8'h26, "R10 no uip in set mode");
    pulseDone(8'h59, 8'h59, 8'h23);
    rdReg(7'd0, 8'h21, "R13 frozen in set mode");
    // R8 system reset
    wrReg(7'd11, 8'h6A);
    pulseTick();
    checkIrq(1'b1, "R8 irq before");
    @(negedge clk); sysReset = 1'b1;
    @(negedge clk); sysReset = 1'b0;
    checkIrq(1'b0, "R8 irq after");
    rdReg(7'd11, 8'h02, "R8 mode");
    rdReg(7'd12, 8'h00, "R8 flags");
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule